// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock. The same shift register serves the sending side and the receiving side. While sending, message bits go in most significant bit first and also pass straight through to the serial output. As soon as the last message bit has been taken, the register holds the n-bit check value. Flipping the mode line then turns the register into a plain shift path that sends the check value out, most significant bit first, over n clocks. No zero-padding shifts are needed between the message and its check value.

While receiving, the mode line stays in make/test for the whole frame of message plus check value. After the last bit, an all-zero register means the frame divides exactly by the generator, and the data-OK flag goes high. A synchronous clear starts every frame. The register moves only on cycles where the valid strobe is high. The degree n and the generator coefficients below x^n are parameters, so one design covers the common 12-bit and 16-bit generators.

Top module: `serial_crc_unit`

## Requirements
- R1: After `rst_n` goes low, or on the clock after `clr` is high, the register is all zero, so `crc_ok` reads 1. `clr` takes priority over `din_vld`.
- R2: On a clock where `din_vld` is low and `clr` is low, the register keeps its value whatever `din` and `calc_mode` are.
- R3: While `calc_mode` is 1, `dout` equals `din` in the same cycle.
- R4: With `calc_mode` at 1, the register starts at zero and takes k message bits MSB first. The register then holds the remainder of x^n·M(x) divided by P(x). For example, message 110011 with P = x^4+x^3+1 (parameter `POLY` = 4'b1001, N = 4) gives 1001.
- R5: While `calc_mode` is 0, each valid clock shifts the register up one place with no feedback and a zero fill at the bottom. `dout` shows the top register bit, so the check value leaves MSB first in N clocks, and the register is zero afterwards.
- R6: A frame of message followed by its correct check value, fed with `calc_mode` at 1 from a cleared register, leaves `crc_ok` at 1. Example: 1100111001 for the 4-bit generator above.
- R7: A frame with any single bit inverted leaves `crc_ok` at 0.
- R8: A frame with an error burst of length at most N leaves `crc_ok` at 0. The burst's first and last bits are inverted and the bits in between are arbitrary.
- R9: `POLY` holds the generator coefficients of x^(N-1) down to x^0, with the x^N term implied. The block works for CRC-12 (N=12, 'h80F), CRC-16 (N=16, 'h8005) and CRC-CCITT (N=16, 'h1021).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous frame-start clear |
| din | input | 1 | Serial data in, MSB first |
| din_vld | input | 1 | Advance the register this cycle |
| calc_mode | input | 1 | 1: make/test CRC, 0: shift out CRC |
| dout | output | 1 | Serial data out |
| crc_ok | output | 1 | High when the register is all zero |

## Verification
A wrong feedback tap or a wrong shift is invisible while the message goes through, because `dout` just copies `din` in that phase. It first shows up at the port as a wrong bit during the N-clock shift-out. On the receive side it shows up as a wrong `crc_ok` right after the last frame bit. A register that moves while the valid strobe is low shows the same symptoms once gaps have been inserted into a message. The checks therefore compare every shifted-out bit, and `crc_ok` at the end of each frame, against a long-division model for four generators, with and without valid gaps and with injected single-bit and burst errors.

// File: rtl/serial_crc_unit.sv
module serial_crc_unit #(
  parameter int N = 16,
  parameter logic [N-1:0] POLY = 16'h8005
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  input  logic din_vld,
  input  logic calc_mode,
  output logic dout,
  output logic crc_ok
);

  logic [N-1:0] rem_q;
  logic         quo_bit;
  logic [N-1:0] up_shift;

  assign quo_bit  = din ^ rem_q[N-1];
  assign up_shift = {rem_q[N-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rem_q <= '0;
    else if (clr)
      rem_q <= '0;
    else if (din_vld)
      rem_q <= calc_mode ? (up_shift ^ ({N{quo_bit}} & POLY)) : up_shift;
  end

  assign dout   = calc_mode ? din : rem_q[N-1];
  assign crc_ok = ~|rem_q;

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> crc_ok);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !din_vld) |=> $stable(rem_q));

  // R5
  shift_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && din_vld && !calc_mode) |=> (rem_q[N-1] == $past(rem_q[N-2]) && !rem_q[0]));

  // R4
  zero_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && din_vld && calc_mode && crc_ok && !din) |=> crc_ok);

endmodule

// File: tb/sim_serial_crc_unit.sv
module sim_serial_crc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, vld = 1'b0, mode = 1'b1;
  logic [3:0] din = '0;
  wire  [3:0] dout, ok;
  int n_chk = 0, n_bad = 0;

  localparam int NW[4] = '{4, 12, 16, 16};
  localparam logic [15:0] PW[4] = '{16'h0009, 16'h080F, 16'h8005, 16'h1021};

  always #5 clk = ~clk;

  serial_crc_unit #(.N(4),  .POLY(4'h9))     u0 (.clk(clk), .rst_n(rst_n), .clr(clr), .din(din[0]), .din_vld(vld), .calc_mode(mode), .dout(dout[0]), .crc_ok(ok[0]));
  serial_crc_unit #(.N(12), .POLY(12'h80F))  u1 (.clk(clk), .rst_n(rst_n), .clr(clr), .din(din[1]), .din_vld(vld), .calc_mode(mode), .dout(dout[1]), .crc_ok(ok[1]));
  serial_crc_unit #(.N(16), .POLY(16'h8005)) u2 (.clk(clk), .rst_n(rst_n), .clr(clr), .din(din[2]), .din_vld(vld), .calc_mode(mode), .dout(dout[2]), .crc_ok(ok[2]));
  serial_crc_unit #(.N(16), .POLY(16'h1021)) u3 (.clk(clk), .rst_n(rst_n), .clr(clr), .din(din[3]), .din_vld(vld), .calc_mode(mode), .dout(dout[3]), .crc_ok(ok[3]));

  function automatic logic [15:0] ref_rem(logic [63:0] msg, int k, int n, logic [15:0] poly);
    logic [95:0] d;
    logic [16:0] g;
    logic [15:0] mask;
    mask = 16'((17'd1 << n) - 17'd1);
    g = (17'd1 << n) | 17'(poly & mask);
    d = 96'(msg) << n;
    for (int i = k + n - 1; i >= n; i--)
      if (d[i]) d = d ^ (96'(g) << (i - n));
    return d[15:0] & mask;
  endfunction

  task automatic chk(string req, int idx, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s inst%0d actual=%0h expected=%0h", req, idx, act, exp);
    end
  endtask

  task automatic feed(logic [3:0] bits, logic m);
    @(negedge clk);
    din = bits; vld = 1'b1; mode = m; clr = 1'b0;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    vld = 1'b0; din = 4'($urandom); mode = 1'($urandom);
    #1;
  endtask

  task automatic do_clr();
    @(negedge clk);
    clr = 1'b1; vld = 1'($urandom); mode = 1'b1; din = 4'($urandom);
    @(negedge clk);
    clr = 1'b0; vld = 1'b0;
    #1;
    for (int i = 0; i < 4; i++) chk("R1 clear", i, 32'(ok[i]), 32'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    for (int i = 0; i < 4; i++) chk("R1 reset", i, 32'(ok[i]), 32'd1);
    rst_n = 1'b1;
  endtask

  task automatic t_tx(logic [63:0] msg, int k, bit gaps);
    logic [15:0] got [4];
    logic [15:0] exp;
    do_clr();
    for (int j = k - 1; j >= 0; j--) begin
      if (gaps && ($urandom % 3 == 0)) idle();
      feed({4{msg[j]}}, 1'b1);
      if (j % 4 == 0)
        for (int i = 0; i < 4; i++) chk("R3 passthru", i, 32'(dout[i]), 32'(msg[j]));
    end
    for (int i = 0; i < 4; i++) got[i] = '0;
    for (int b = 0; b < 16; b++) begin
      if (gaps && ($urandom % 3 == 0)) idle();
      feed(4'($urandom), 1'b0);
      for (int i = 0; i < 4; i++)
        if (b < NW[i]) got[i] = {got[i][14:0], dout[i]};
        else chk("R5 zero fill", i, 32'(dout[i]), 32'd0);
    end
    for (int i = 0; i < 4; i++) begin
      exp = ref_rem(msg, k, NW[i], PW[i]);
      chk(gaps ? "R2 R4 R9 crc gaps" : "R4 R9 crc", i, 32'(got[i]), 32'(exp));
    end
    idle();
    for (int i = 0; i < 4; i++) chk("R5 empty", i, 32'(ok[i]), 32'd1);
  endtask

  task automatic t_rx(logic [63:0] msg, int k, int epos, int blen, string req);
    logic [79:0] fr [4];
    logic [79:0] emask;
    logic [3:0]  bits;
    for (int i = 0; i < 4; i++)
      fr[i] = (80'(msg) << NW[i]) | 80'(ref_rem(msg, k, NW[i], PW[i]));
    emask = '0;
    if (blen > 0) begin
      for (int b = 0; b < blen; b++) emask[epos + b] = 1'($urandom);
      emask[epos] = 1'b1;
      emask[epos + blen - 1] = 1'b1;
    end
    do_clr();
    for (int j = k + 15; j >= 0; j--) begin
      for (int i = 0; i < 4; i++) bits[i] = fr[i][j] ^ emask[j];
      feed(bits, 1'b1);
    end
    idle();
    for (int i = 0; i < 4; i++) chk(req, i, 32'(ok[i]), (blen == 0) ? 32'd1 : 32'd0);
  endtask

  task automatic t_vector();
    logic [3:0] got;
    do_clr();
    for (int j = 5; j >= 0; j--) feed({4{6'b110011 >> j}} & 4'b0001, 1'b1);
    got = '0;
    for (int b = 0; b < 4; b++) begin
      feed(4'b0, 1'b0);
      got = {got[2:0], dout[0]};
    end
    chk("R4 vector 110011", 0, 32'(got), 32'b1001);
    do_clr();
    for (int j = 9; j >= 0; j--) feed({3'b0, 1'(10'b1100111001 >> j)}, 1'b1);
    idle();
    chk("R6 vector frame", 0, 32'(ok[0]), 32'd1);
  endtask

  task automatic t_hold_clr();
    do_clr();
    idle(); idle(); idle();
    for (int i = 0; i < 4; i++) chk("R2 hold idle", i, 32'(ok[i]), 32'd1);
    for (int j = 0; j < 5; j++) feed(4'hF, 1'b1);
    idle();
    for (int i = 0; i < 4; i++) chk("R4 nonzero", i, 32'(ok[i]), 32'd0);
    do_clr();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] m;
    int k;
    t_reset();
    t_vector();
    t_hold_clr();
    t_tx(64'b110011, 6, 1'b0);
    for (int t = 0; t < 12; t++) begin
      k = 8 + int'($urandom % 40);
      m = {$urandom, $urandom} & ((64'd1 << k) - 64'd1);
      t_tx(m, k, t[0]);
      t_rx(m, k, 0, 0, "R6 clean");
      t_rx(m, k, int'($urandom % (k + 4)), 1, "R7 single");
      t_rx(m, k, int'($urandom % (k + 1)), 2 + int'($urandom % 3), "R8 burst");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule